// File: doc/BRIEF.md
# Two-Word Floating Multiplier

This unit multiplies two numbers held in a two-word floating format: a signed two's-complement exponent word and a signed fraction word. The fraction has its binary point just below the sign bit, so it covers [-1, 1). The unit adds the two exponents and forms the signed fractional product of the two fractions. It then renormalizes the wide product by counting its redundant sign bits. It shifts the product left by that count and subtracts the count from the exponent sum.

Operands arrive with a valid strobe, one pair per cycle at most. The result comes out with its own valid strobe after a fixed latency. The fraction width is a parameter. At 16 bits the fractions are multiplied in one signed product and the result is registered after one cycle. Wider fractions are split into two halves. The unit forms four partial products: low by low unsigned, two mixed high-by-low cross terms, and high by high signed. These are registered in a first stage. In the second stage the low contribution is shifted right before it is accumulated, and the sum is normalized, for a latency of two cycles. Overflow of the exponent range, rounding modes and special values are not handled. The exponent simply wraps.

Top module: `tw_fmul`

## Requirements
- R1: The result exponent equals a_exp + b_exp minus the normalization count, taken modulo 2^EXP_W. The normalization count is the number of redundant sign bits of the 2*FRAC_W-bit fractional product.
- R2: The fractional product is the two's-complement integer product of the fractions, shifted left by one bit. The result fraction is the upper FRAC_W bits of this product after it is shifted left by the normalization count. Lower bits are dropped (truncation).
- R3: Every nonzero result fraction is normalized: its bit FRAC_W-1 differs from its bit FRAC_W-2. This holds even when the operands are not normalized.
- R4: When both fractions equal the most negative value (-1), the fractional product saturates to the most positive 2*FRAC_W-bit value. The result is then a fraction of 0x7FFFFFFF (for FRAC_W=32) with exponent a_exp + b_exp.
- R5: A zero product gives fraction 0, and its exponent is a_exp + b_exp - (FRAC_W-1).
- R6: out_vld rises exactly LAT cycles after an accepted in_vld, where LAT is 2 for FRAC_W above 16 and 1 otherwise. A new operand pair may be accepted on every cycle.
- R7: out_exp and out_frac keep their values on every cycle on which out_vld is low.
- R8: While rst is high, out_vld, out_exp and out_frac are all zero.
- R9: A nonzero result has a sign bit equal to the exclusive-or of the operand fraction sign bits.
- R10: When the exponent sum exceeds the EXP_W-bit signed range, it wraps modulo 2^EXP_W with no flag and no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand pair present |
| a_exp | input | EXP_W | Exponent of operand A, two's complement |
| a_frac | input | FRAC_W | Fraction of operand A, signed, binary point below sign |
| b_exp | input | EXP_W | Exponent of operand B, two's complement |
| b_frac | input | FRAC_W | Fraction of operand B, signed, binary point below sign |
| out_vld | output | 1 | Result present |
| out_exp | output | EXP_W | Result exponent |
| out_frac | output | FRAC_W | Result fraction, normalized |

## Verification
With normalized operands the product never needs more than one bit of normalization shift. The deep normalization paths and the truncated low bits are therefore only reached with operands that break the normalization assumption. The stimulus feeds fractions that are arithmetically shifted right by random amounts, which forces counts far above one on both signs. Directed pairs cover the (-1)×(-1) saturation, zero operands and exponent sums that wrap. Random gaps in the valid strobe test the holding of the output.

// File: rtl/tw_fmul_pkg.sv
package tw_fmul_pkg;

  // Fractions wider than this are split into halves for the multiply.
  localparam int unsigned TW_SPLIT_W = 16;

  function automatic int unsigned tw_latency(input int unsigned frac_w);
    return (frac_w > TW_SPLIT_W) ? 2 : 1;
  endfunction

endpackage

// File: rtl/tw_fmul_prod.sv
module tw_fmul_prod
  import tw_fmul_pkg::*;
#(
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned EXP_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [EXP_W-1:0]      a_exp,
  input  logic [FRAC_W-1:0]     a_frac,
  input  logic [EXP_W-1:0]      b_exp,
  input  logic [FRAC_W-1:0]     b_frac,
  output logic                  p_vld,
  output logic [2*FRAC_W-1:0]   p_prod,
  output logic [EXP_W-1:0]      p_exp
);

  localparam int unsigned PW = 2 * FRAC_W;
  localparam logic [FRAC_W-1:0] FMIN = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [PW-1:0]     PMAX = {1'b0, {(PW-1){1'b1}}};

  logic             sat_in;
  logic [EXP_W-1:0] esum_in;

  assign sat_in  = (a_frac == FMIN) && (b_frac == FMIN);
  assign esum_in = a_exp + b_exp;

  generate
    if (FRAC_W > TW_SPLIT_W) begin : g_split
      localparam int unsigned H  = FRAC_W / 2;
      localparam int unsigned XW = 2 * H + 1;
      localparam int unsigned AW = 3 * H;

      logic [H-1:0] a_hi, a_lo, b_hi, b_lo;
      assign a_hi = a_frac[FRAC_W-1:H];
      assign a_lo = a_frac[H-1:0];
      assign b_hi = b_frac[FRAC_W-1:H];
      assign b_lo = b_frac[H-1:0];

      // partial products of the halves
      logic        [2*H-1:0] ll_n;
      logic signed [XW-1:0]  cx_n, cy_n;
      logic signed [2*H-1:0] hh_n;

      always_comb begin
        ll_n = {{H{1'b0}}, a_lo} * {{H{1'b0}}, b_lo};
        cx_n = $signed({{(H+1){a_hi[H-1]}}, a_hi}) * $signed({{(H+1){1'b0}}, b_lo});
        cy_n = $signed({{(H+1){b_hi[H-1]}}, b_hi}) * $signed({{(H+1){1'b0}}, a_lo});
        hh_n = $signed({{H{a_hi[H-1]}}, a_hi}) * $signed({{H{b_hi[H-1]}}, b_hi});
      end

      // stage one registers
      logic                  vld_q, sat_q;
      logic [EXP_W-1:0]      esum_q;
      logic        [2*H-1:0] ll_q;
      logic signed [XW-1:0]  cx_q, cy_q;
      logic signed [2*H-1:0] hh_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q <= 1'b0;
        end else begin
          vld_q <= in_vld;
        end
        if (in_vld) begin
          ll_q   <= ll_n;
          cx_q   <= cx_n;
          cy_q   <= cy_n;
          hh_q   <= hh_n;
          sat_q  <= sat_in;
          esum_q <= esum_in;
        end
      end

      // stage two: accumulate above the low half, then append the low bits
      logic [AW-1:0] acc;
      logic [PW-1:0] full;

      always_comb begin
        acc  = {hh_q, {H{1'b0}}}
             + {{(AW-XW){cx_q[XW-1]}}, cx_q}
             + {{(AW-XW){cy_q[XW-1]}}, cy_q}
             + {{(2*H){1'b0}}, ll_q[2*H-1:H]};
        full = {acc, ll_q[H-1:0]};
      end

      assign p_vld  = vld_q;
      assign p_exp  = esum_q;
      assign p_prod = sat_q ? PMAX : (full << 1);
    end else begin : g_direct
      logic [PW-1:0] full;

      always_comb begin
        full = $signed({{FRAC_W{a_frac[FRAC_W-1]}}, a_frac})
             * $signed({{FRAC_W{b_frac[FRAC_W-1]}}, b_frac});
      end

      assign p_vld  = in_vld;
      assign p_exp  = esum_in;
      assign p_prod = sat_in ? PMAX : (full << 1);
    end
  endgenerate

endmodule

// File: rtl/tw_fmul_norm.sv
module tw_fmul_norm #(
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned EXP_W  = 16
) (
  input  logic [2*FRAC_W-1:0] prod,
  input  logic [EXP_W-1:0]    esum,
  output logic [FRAC_W-1:0]   frac,
  output logic [EXP_W-1:0]    expo
);

  localparam int unsigned PW = 2 * FRAC_W;
  localparam int unsigned CW = $clog2(PW);

  logic [CW-1:0] rsb;
  logic [CW-1:0] cnt;
  logic          run;
  logic [PW-1:0] shifted;

  // redundant sign bit count of the wide product
  always_comb begin
    rsb = '0;
    run = 1'b1;
    for (int i = PW - 2; i >= 0; i--) begin
      if (run && (prod[i] == prod[PW-1])) begin
        rsb = rsb + CW'(1);
      end else begin
        run = 1'b0;
      end
    end
  end

  assign cnt     = (prod == '0) ? CW'(FRAC_W - 1) : rsb;
  assign shifted = prod << cnt;
  assign frac    = FRAC_W'(shifted >> FRAC_W);
  assign expo    = esum - {{(EXP_W-CW){1'b0}}, cnt};

endmodule

// File: rtl/tw_fmul.sv
module tw_fmul
  import tw_fmul_pkg::*;
#(
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned EXP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W-1:0] b_frac,
  output logic              out_vld,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac
);

  logic                p_vld;
  logic [2*FRAC_W-1:0] p_prod;
  logic [EXP_W-1:0]    p_exp;
  logic [FRAC_W-1:0]   n_frac;
  logic [EXP_W-1:0]    n_exp;

  tw_fmul_prod #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_prod (
    .clk    (clk),
    .rst    (rst),
    .in_vld (in_vld),
    .a_exp  (a_exp),
    .a_frac (a_frac),
    .b_exp  (b_exp),
    .b_frac (b_frac),
    .p_vld  (p_vld),
    .p_prod (p_prod),
    .p_exp  (p_exp)
  );

  tw_fmul_norm #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_norm (
    .prod (p_prod),
    .esum (p_exp),
    .frac (n_frac),
    .expo (n_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_exp  <= '0;
      out_frac <= '0;
    end else begin
      out_vld <= p_vld;
      if (p_vld) begin
        out_exp  <= n_exp;
        out_frac <= n_frac;
      end
    end
  end

endmodule

// File: rtl/tw_fmul_chk.sv
module tw_fmul_chk
  import tw_fmul_pkg::*;
#(
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned EXP_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_vld,
  input logic [FRAC_W-1:0] a_frac,
  input logic [FRAC_W-1:0] b_frac,
  input logic              out_vld,
  input logic [EXP_W-1:0]  out_exp,
  input logic [FRAC_W-1:0] out_frac
);

  localparam int unsigned LAT = tw_latency(FRAC_W);

  logic [LAT-1:0] vp, zp, sp;

  always_ff @(posedge clk) begin
    if (rst) begin
      vp <= '0;
      zp <= '0;
      sp <= '0;
    end else begin
      vp <= (vp << 1) | LAT'(in_vld);
      zp <= (zp << 1) | LAT'((a_frac == '0) || (b_frac == '0));
      sp <= (sp << 1) | LAT'(a_frac[FRAC_W-1] ^ b_frac[FRAC_W-1]);
    end
  end

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    out_vld == vp[LAT-1]);

  p_normalized_r3: assert property (@(posedge clk) disable iff (rst)
    (out_vld && (out_frac != '0)) |-> (out_frac[FRAC_W-1] != out_frac[FRAC_W-2]));

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((out_frac == '0) == zp[LAT-1]));

  p_sign_r9: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !zp[LAT-1]) |-> (out_frac[FRAC_W-1] == sp[LAT-1]));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_frac) && $stable(out_exp)));

endmodule

bind tw_fmul tw_fmul_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/tb_tw_fmul.sv
module tb_tw_fmul;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 32;
  localparam int EW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [FW-1:0] a_frac = '0, b_frac = '0;
  logic          out_vld;
  logic [EW-1:0] out_exp;
  logic [FW-1:0] out_frac;

  int compared = 0;
  int mismatched = 0;
  logic started = 1'b0;
  string cur_tag = "R2";

  tw_fmul #(.FRAC_W(FW), .EXP_W(EW)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .a_exp(a_exp), .a_frac(a_frac), .b_exp(b_exp), .b_frac(b_frac),
    .out_vld(out_vld), .out_exp(out_exp), .out_frac(out_frac)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference for one product: {exponent, fraction}
  function automatic logic [EW+FW-1:0] ref_mul(input logic [EW-1:0] ae, input logic [FW-1:0] af,
                                               input logic [EW-1:0] be, input logic [FW-1:0] bf);
    longint fa, fb, pr;
    logic [63:0] p, sh;
    logic [EW-1:0] e;
    int cnt;
    fa = longint'($signed(af));
    fb = longint'($signed(bf));
    pr = fa * fb;
    p = 64'(pr) << 1;
    if (af == 32'h8000_0000 && bf == 32'h8000_0000) p = 64'h7FFF_FFFF_FFFF_FFFF;
    cnt = 0;
    if (p == 64'd0) cnt = FW - 1;
    else while (cnt < 63 && p[62-cnt] == p[63]) cnt++;
    sh = p << cnt;
    e = ae + be - EW'(cnt);
    return {e, sh[63:32]};
  endfunction

  // reference pipeline: one operand stage, one output stage
  logic          s_vld = 1'b0, o_vld = 1'b0;
  logic [EW-1:0] s_exp = '0, o_exp = '0;
  logic [FW-1:0] s_frac = '0, o_frac = '0;
  string         s_tag = "R8", o_tag = "R8";

  always @(posedge clk) begin
    logic [EW+FW-1:0] r;
    started <= 1'b1;
    if (rst) begin
      s_vld <= 1'b0; o_vld <= 1'b0; o_exp <= '0; o_frac <= '0; o_tag <= "R8";
    end else begin
      s_vld <= in_vld;
      if (in_vld) begin
        r = ref_mul(a_exp, a_frac, b_exp, b_frac);
        s_exp <= r[EW+FW-1:FW];
        s_frac <= r[FW-1:0];
        s_tag <= cur_tag;
      end
      o_vld <= s_vld;
      if (s_vld) begin
        o_exp <= s_exp; o_frac <= s_frac; o_tag <= s_tag;
      end
    end
  end

  // compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (started) begin
      string t;
      t = rst ? "R8" : (o_vld ? o_tag : "R7");
      compared++;
      if (out_vld !== o_vld) begin
        mismatched++;
        $display("FAIL R6 %s out_vld actual %0b expected %0b", t, out_vld, o_vld);
      end
      if (out_frac !== o_frac || out_exp !== o_exp) begin
        mismatched++;
        $display("FAIL %s actual exp %h frac %h expected exp %h frac %h",
                 t, out_exp, out_frac, o_exp, o_frac);
      end
    end
  end

  task automatic apply(input logic [EW-1:0] ae, input logic [FW-1:0] af,
                       input logic [EW-1:0] be, input logic [FW-1:0] bf, input string tag);
    @(negedge clk);
    in_vld = 1'b1; a_exp = ae; a_frac = af; b_exp = be; b_frac = bf; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      a_frac = $urandom; b_frac = $urandom; a_exp = 16'($urandom); b_exp = 16'($urandom);
    end
  endtask

  function automatic logic [FW-1:0] norm_rand();
    logic [FW-1:0] v;
    v = $urandom;
    v[FW-2] = ~v[FW-1];
    return v;
  endfunction

  initial begin
    // R8: reset held for several cycles with inputs toggling
    repeat (3) begin
      @(negedge clk);
      in_vld = 1'b1; a_frac = 32'h4000_0000; b_frac = 32'h4000_0000;
    end
    @(negedge clk);
    rst = 1'b0; in_vld = 1'b0;
    idle(2);

    // R1 R2: 0.5 * 0.5 = 0.25 -> 0.5 with exponent 3+4-1
    apply(16'd3, 32'h4000_0000, 16'd4, 32'h4000_0000, "R1 R2");
    // R4: -1 * -1 saturates
    apply(16'd5, 32'h8000_0000, 16'hFFFE, 32'h8000_0000, "R4");
    // R5: zero operand
    apply(16'd10, 32'h0000_0000, 16'd7, 32'h5555_5555, "R5");
    apply(16'hFFF0, 32'h9000_0000, 16'd2, 32'h0000_0000, "R5");
    // R9: sign combinations
    apply(16'd0, 32'hA000_0000, 16'd0, 32'h6000_0000, "R9");
    apply(16'd1, 32'hA000_0000, 16'd1, 32'hB000_0000, "R9");
    apply(16'd1, 32'h8000_0000, 16'd1, 32'h7FFF_FFFF, "R9");
    // R10: exponent wrap in both directions
    apply(16'h7FFF, 32'h7FFF_FFFF, 16'h7FFF, 32'h7FFF_FFFF, "R10");
    apply(16'h8000, 32'h4000_0000, 16'h8000, 32'hC000_0000, "R10");
    idle(3);

    // R3: non-normalized operands force deep normalization
    for (int i = 0; i < 150; i++) begin
      logic [FW-1:0] x, y;
      x = FW'($signed(norm_rand()) >>> ($urandom % 31));
      y = FW'($signed(norm_rand()) >>> ($urandom % 31));
      apply(16'($urandom), x, 16'($urandom), y, "R3 R1");
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end

    // R6: back-to-back stream of normalized operands
    for (int i = 0; i < 100; i++)
      apply(16'($urandom), norm_rand(), 16'($urandom), norm_rand(), "R6 R2");

    // R2 R7: random operands with random gaps
    for (int i = 0; i < 200; i++) begin
      apply(16'($urandom), norm_rand(), 16'($urandom), $urandom, "R2 R7");
      if ($urandom % 3 == 0) idle(1 + $urandom % 4);
    end
    idle(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule